// File: doc/BRIEF.md
# Subscriber-Line Switch State Controller

This block is the digital control core of a solid-state access switch on a telephone line card. A 3-bit mode code picks one of eight switch arrangements, and the block drives ten switch-enable outputs. The mode code passes through a transparent hold stage. While the hold input is low, new codes take effect at once. While it is high, the last code captured is kept.

The block starts with every switch open and stays that way until the hold input is first pulled low. Any of three conditions forces all switches open and re-arms that lockout: the supply is not good, the battery is missing, or a thermal fault is present. A change from Ringing to Talk is sequenced in one of two orders, chosen by a configuration input. In break-before-make order, all switches are open for a gap. In make-before-break order, the talk and ringing paths overlap. The length of the gap or overlap is programmable.

Top module: `line_switch_ctrl`

## Requirements
- R1: Switch bit i drives switch i+1. Single modes close these switches: code 001 closes bits 0 and 1 (0x003); code 010 closes bits 2 and 3 (0x00C); code 011 closes bits 4 and 5 (0x030); code 100 closes bits 6 and 7 (0x0C0); code 101 closes bits 8 and 9 (0x300). Code 000 opens all switches.
- R2: Code 110 closes bits 4, 5, 8 and 9 (0x330). Code 111 closes bits 4 to 7 (0x0F0) when the parameter HAS_COMBO is 1. When HAS_COMBO is 0, code 111 opens all switches.
- R3: While hold_n_i is 0 and no fault is present, the pattern for mode_i appears on sw_en_o one clock edge later.
- R4: While hold_n_i is 1, the captured mode is kept, and changes on mode_i do not change sw_en_o.
- R5: After reset, sw_en_o stays 0 while hold_n_i stays 1, whatever mode_i is. Switches close only after hold_n_i is first driven to 0.
- R6: When supply_ok_i is 0 at a clock edge, sw_en_o is 0 after that edge.
- R7: When batt_ok_i is 0 at a clock edge, sw_en_o is 0 after that edge.
- R8: When therm_flt_i is 1 at a clock edge, sw_en_o is 0 after that edge. After any fault clears, the lockout of R5 applies again.
- R9: The block starts a Ringing-to-Talk change when the output shows Ringing and Talk is requested. With seq_mbb_i at 0, all switches open for seq_len_i+1 cycles, and then 0x003 appears.
- R10: With seq_mbb_i at 1, 0x00F (talk and ringing switches together) appears for seq_len_i+1 cycles, and then 0x003 appears. The length and the order are sampled at the start of the change.
- R11: A fault during a Ringing-to-Talk change stops the change, and sw_en_o goes to 0 at the same edge.
- R12: All outputs are registered. During reset, sw_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Requested mode code |
| hold_n_i | input | 1 | 0 = transparent, 1 = hold (idles high) |
| supply_ok_i | input | 1 | Supply-good flag |
| batt_ok_i | input | 1 | Battery-present flag |
| therm_flt_i | input | 1 | Thermal-fault flag |
| seq_mbb_i | input | 1 | Ringing-to-Talk order: 1 = make-before-break |
| seq_len_i | input | CNT_W | Gap or overlap length minus one, in cycles |
| sw_en_o | output | 10 | Switch enables, bit i = switch i+1 |

## Verification
The hardest situation to reach is a fault, or a new request, arriving while a Ringing-to-Talk gap or overlap is running. That needs Ringing on the output, a Talk request, and an event inside a window only a few cycles long. The random stimulus favours the Ringing and Talk codes and keeps sequence lengths short, so such windows open often. Directed cases add a supply drop in the middle of a break-before-make gap, and a fault that clears while the hold input is high, which checks that the lockout re-arms.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int NUM_SW = 10;

  typedef enum logic [2:0] {
    MD_OFF      = 3'd0,
    MD_TALK     = 3'd1,
    MD_RING     = 3'd2,
    MD_TOUT     = 3'd3,
    MD_RGT      = 3'd4,
    MD_TIN      = 3'd5,
    MD_TIN_TOUT = 3'd6,
    MD_TOUT_RGT = 3'd7
  } mode_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_GAP  = 2'd1,
    SQ_OVL  = 2'd2
  } seq_t;

  // Map an unsupported combined request onto all-open.
  function automatic mode_t legal_mode(logic [2:0] code, bit has_combo);
    mode_t m;
    m = mode_t'(code);
    if (m == MD_TOUT_RGT && !has_combo) m = MD_OFF;
    return m;
  endfunction

  // Switch i+1 sits on bit i; each pair of switches is one path.
  function automatic logic [NUM_SW-1:0] pair_bits(int pair_idx);
    logic [NUM_SW-1:0] v;
    v = '0;
    v[2*pair_idx]   = 1'b1;
    v[2*pair_idx+1] = 1'b1;
    return v;
  endfunction

  function automatic logic [NUM_SW-1:0] sw_pattern(mode_t m);
    logic [NUM_SW-1:0] v;
    case (m)
      MD_TALK:     v = pair_bits(0);
      MD_RING:     v = pair_bits(1);
      MD_TOUT:     v = pair_bits(2);
      MD_RGT:      v = pair_bits(3);
      MD_TIN:      v = pair_bits(4);
      MD_TIN_TOUT: v = pair_bits(2) | pair_bits(4);
      MD_TOUT_RGT: v = pair_bits(2) | pair_bits(3);
      default:     v = '0;
    endcase
    return v;
  endfunction

  function automatic bit pattern_is_legal(logic [NUM_SW-1:0] v, bit has_combo);
    bit ok;
    ok = (v == (pair_bits(0) | pair_bits(1)));
    for (int k = 0; k < 8; k++) begin
      if (v == sw_pattern(legal_mode(3'(k), has_combo))) ok = 1'b1;
    end
    return ok;
  endfunction
endpackage

// File: rtl/lsc_hold_latch.sv
module lsc_hold_latch
  import lsc_pkg::*;
#(
  parameter bit HAS_COMBO = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  mode_i,
  input  logic        hold_n_i,
  input  logic        fault_i,
  output mode_t       tgt_mode_o,
  output mode_t       held_mode_o,
  output logic        locked_o
);
  mode_t held_q;
  logic  locked_q;
  mode_t in_mode;

  assign in_mode = legal_mode(mode_i, HAS_COMBO);

  always_comb begin
    if (fault_i)        tgt_mode_o = MD_OFF;
    else if (!hold_n_i) tgt_mode_o = in_mode;
    else if (locked_q)  tgt_mode_o = MD_OFF;
    else                tgt_mode_o = held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q   <= MD_OFF;
      locked_q <= 1'b1;
    end else if (fault_i) begin
      held_q   <= MD_OFF;
      locked_q <= 1'b1;
    end else if (!hold_n_i) begin
      held_q   <= in_mode;
      locked_q <= 1'b0;
    end
  end

  assign held_mode_o = held_q;
  assign locked_o    = locked_q;
endmodule

// File: rtl/lsc_seq.sv
module lsc_seq
  import lsc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_i,
  input  mode_t             tgt_mode_i,
  input  logic              mbb_i,
  input  logic [CNT_W-1:0]  len_i,
  output logic [NUM_SW-1:0] sw_en_o,
  output logic              busy_o,
  output logic              start_o
);
  localparam logic [NUM_SW-1:0] BOTH_PATHS = 10'h00F;

  seq_t              st_q;
  mode_t             cur_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [NUM_SW-1:0] sw_q;
  logic              cnt_done;

  assign cnt_done = (cnt_q == '0);
  assign start_o  = !fault_i && (st_q == SQ_IDLE) && (cur_q == MD_RING) &&
                    (tgt_mode_i == MD_TALK);
  assign busy_o   = (st_q != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cur_q <= MD_OFF;
      cnt_q <= '0;
      sw_q  <= '0;
    end else if (fault_i) begin
      st_q  <= SQ_IDLE;
      cur_q <= MD_OFF;
      cnt_q <= '0;
      sw_q  <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (start_o) begin
            cnt_q <= len_i;
            st_q  <= mbb_i ? SQ_OVL : SQ_GAP;
            sw_q  <= mbb_i ? BOTH_PATHS : '0;
          end else begin
            sw_q  <= sw_pattern(tgt_mode_i);
            cur_q <= tgt_mode_i;
          end
        end
        default: begin
          if (cnt_done) begin
            sw_q  <= sw_pattern(MD_TALK);
            cur_q <= MD_TALK;
            st_q  <= SQ_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      endcase
    end
  end

  assign sw_en_o = sw_q;
endmodule

// File: rtl/line_switch_ctrl.sv
module line_switch_ctrl
  import lsc_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter bit HAS_COMBO = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_i,
  input  logic             hold_n_i,
  input  logic             supply_ok_i,
  input  logic             batt_ok_i,
  input  logic             therm_flt_i,
  input  logic             seq_mbb_i,
  input  logic [CNT_W-1:0] seq_len_i,
  output logic [9:0]       sw_en_o
);
  logic  fault_w;
  mode_t tgt_w;
  mode_t held_w;
  logic  locked_w;
  logic  seq_busy_w;
  logic  seq_start_w;

  assign fault_w = !supply_ok_i || !batt_ok_i || therm_flt_i;

  lsc_hold_latch #(.HAS_COMBO(HAS_COMBO)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .hold_n_i    (hold_n_i),
    .fault_i     (fault_w),
    .tgt_mode_o  (tgt_w),
    .held_mode_o (held_w),
    .locked_o    (locked_w)
  );

  lsc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_i    (fault_w),
    .tgt_mode_i (tgt_w),
    .mbb_i      (seq_mbb_i),
    .len_i      (seq_len_i),
    .sw_en_o    (sw_en_o),
    .busy_o     (seq_busy_w),
    .start_o    (seq_start_w)
  );
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker
  import lsc_pkg::*;
#(
  parameter bit HAS_COMBO = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_i,
  input logic       hold_n_i,
  input logic       supply_ok_i,
  input logic       batt_ok_i,
  input logic       therm_flt_i,
  input logic       seq_mbb_i,
  input logic [9:0] sw_en_o,
  input logic       fault_w,
  input mode_t      held_w,
  input logic       locked_w,
  input logic       seq_busy_w,
  input logic       seq_start_w
);
  p_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pattern_is_legal(sw_en_o, HAS_COMBO));

  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n_i && !fault_w && !seq_busy_w && !seq_start_w) |=>
      (sw_en_o == sw_pattern(legal_mode($past(mode_i), HAS_COMBO))));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_n_i && !fault_w) |=> $stable(held_w));

  p_lock_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_w && hold_n_i) |=> (sw_en_o == '0));

  p_supply_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |=> (sw_en_o == '0));

  p_batt_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !batt_ok_i |=> (sw_en_o == '0));

  p_therm_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    therm_flt_i |=> (sw_en_o == '0));

  p_bbm_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start_w && !seq_mbb_i) |=> (sw_en_o == '0));

  p_mbb_ovl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start_w && seq_mbb_i) |=> (sw_en_o == 10'h00F));

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy_w && fault_w) |=> (!seq_busy_w && sw_en_o == '0));
endmodule

bind line_switch_ctrl lsc_checker #(.HAS_COMBO(HAS_COMBO)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .hold_n_i    (hold_n_i),
  .supply_ok_i (supply_ok_i),
  .batt_ok_i   (batt_ok_i),
  .therm_flt_i (therm_flt_i),
  .seq_mbb_i   (seq_mbb_i),
  .sw_en_o     (sw_en_o),
  .fault_w     (fault_w),
  .held_w      (held_w),
  .locked_w    (locked_w),
  .seq_busy_w  (seq_busy_w),
  .seq_start_w (seq_start_w)
);

// File: tb/line_switch_ctrl_test.sv
`timescale 1ns/1ps
module line_switch_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       hold_n = 1'b1;
  logic       sup = 1'b1;
  logic       bat = 1'b1;
  logic       thm = 1'b0;
  logic       mbb = 1'b0;
  logic [3:0] len = 4'd0;
  logic [9:0] sw_a;
  logic [9:0] sw_b;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  line_switch_ctrl #(.CNT_W(4), .HAS_COMBO(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .hold_n_i(hold_n),
    .supply_ok_i(sup), .batt_ok_i(bat), .therm_flt_i(thm),
    .seq_mbb_i(mbb), .seq_len_i(len), .sw_en_o(sw_a));

  line_switch_ctrl #(.CNT_W(4), .HAS_COMBO(1'b0)) uut_b (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .hold_n_i(hold_n),
    .supply_ok_i(sup), .batt_ok_i(bat), .therm_flt_i(thm),
    .seq_mbb_i(mbb), .seq_len_i(len), .sw_en_o(sw_b));

  // Reference state, written from the requirements.
  bit [9:0] exp_sw;
  bit       m_locked;
  bit [2:0] m_held;
  bit [2:0] m_cur;
  int       m_phase;   // 0 none, 1 open gap, 2 overlap
  int       m_left;

  function automatic bit [9:0] expect_pat(bit [2:0] code);
    case (code)
      3'd1: return 10'b00_0000_0011;
      3'd2: return 10'b00_0000_1100;
      3'd3: return 10'b00_0011_0000;
      3'd4: return 10'b00_1100_0000;
      3'd5: return 10'b11_0000_0000;
      3'd6: return 10'b11_0011_0000;
      3'd7: return 10'b00_1111_0000;
      default: return 10'b0;
    endcase
  endfunction

  task automatic model_edge();
    bit [2:0] tgt;
    if (!sup || !bat || thm) begin
      exp_sw = '0; m_locked = 1; m_held = 0; m_cur = 0; m_phase = 0;
      return;
    end
    tgt = !hold_n ? mode : (m_locked ? 3'd0 : m_held);
    if (!hold_n) begin m_held = mode; m_locked = 0; end
    if (m_phase != 0) begin
      if (m_left == 0) begin exp_sw = expect_pat(3'd1); m_cur = 3'd1; m_phase = 0; end
      else m_left--;
    end else if (m_cur == 3'd2 && tgt == 3'd1) begin
      m_left  = int'(len);
      m_phase = mbb ? 2 : 1;
      exp_sw  = mbb ? 10'h00F : 10'h000;
    end else begin
      exp_sw = expect_pat(tgt);
      m_cur  = tgt;
    end
  endtask

  task automatic check(string tag, bit [9:0] act, bit [9:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: sw_en_o actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge: drive, cross one rising edge, compare.
  task automatic step(bit [2:0] md, bit hn, bit s, bit b, bit t, bit mb,
                      bit [3:0] ln, string tag);
    mode = md; hold_n = hn; sup = s; bat = b; thm = t; mbb = mb; len = ln;
    model_edge();
    @(negedge clk);
    check(tag, sw_a, exp_sw);
  endtask

  task automatic ok_step(bit [2:0] md, bit hn, string tag);
    step(md, hn, 1, 1, 0, 0, 4'd0, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    exp_sw = 0; m_locked = 1; m_held = 0; m_cur = 0; m_phase = 0; m_left = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R12 reset", sw_a, 10'h000);
    rst_n = 1'b1;

    // R5: locked after reset while hold input idles high
    for (int i = 0; i < 3; i++) ok_step(3'd1, 1'b1, "R5 lockout");
    ok_step(3'd1, 1'b0, "R3 release");
    // R1/R2: every code passes through
    for (int k = 0; k < 8; k++) begin
      ok_step(3'(k), 1'b0, (k >= 6) ? "R2 combo" : "R1 decode");
      if (k == 7) check("R2 no-combo variant", sw_b, 10'h000);
    end
    // R4: hold keeps ringing
    ok_step(3'd2, 1'b0, "R3 ring");
    for (int i = 0; i < 4; i++) ok_step(3'(3 + i), 1'b1, "R4 hold");
    // R9: break-before-make, length 3
    for (int i = 0; i < 6; i++) step(3'd1, 0, 1, 1, 0, 0, 4'd3, "R9 bbm");
    ok_step(3'd2, 1'b0, "R9 back ring");
    // R10: make-before-break, length 2
    for (int i = 0; i < 5; i++) step(3'd1, 0, 1, 1, 0, 1, 4'd2, "R10 mbb");
    // R11: supply drop mid-gap
    ok_step(3'd2, 1'b0, "R11 ring");
    step(3'd1, 0, 1, 1, 0, 0, 4'd5, "R11 start");
    step(3'd1, 0, 1, 1, 0, 0, 4'd5, "R11 gap");
    step(3'd1, 0, 0, 1, 0, 0, 4'd5, "R11 abort");
    step(3'd1, 1, 1, 1, 0, 0, 4'd5, "R11 relock");
    // R6/R7/R8 and re-arm
    ok_step(3'd3, 1'b0, "R6 setup");
    step(3'd3, 0, 0, 1, 0, 0, 4'd0, "R6 supply");
    ok_step(3'd3, 1'b0, "R7 setup");
    step(3'd3, 0, 1, 0, 0, 0, 4'd0, "R7 battery");
    ok_step(3'd5, 1'b0, "R8 setup");
    ok_step(3'd5, 1'b1, "R8 held");
    step(3'd5, 1, 1, 1, 1, 0, 4'd0, "R8 thermal");
    for (int i = 0; i < 3; i++) ok_step(3'd5, 1'b1, "R8 rearm");
    ok_step(3'd5, 1'b0, "R8 release");

    // Random phase, biased toward Ringing/Talk and short lengths
    for (int i = 0; i < 4000; i++) begin
      bit [2:0] md;
      int r;
      r  = int'($urandom_range(0, 9));
      md = (r < 4) ? 3'd2 : (r < 7) ? 3'd1 : 3'($urandom_range(0, 7));
      step(md, ($urandom_range(0, 9) < 3),
           ($urandom_range(0, 99) != 0), ($urandom_range(0, 99) != 0),
           ($urandom_range(0, 99) == 0), 1'($urandom_range(0, 1)),
           4'($urandom_range(0, 4)), "RND R9 R10 R11");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule